// File: doc/BRIEF.md
# Two-Lane Serial Result Output Port

This block is the device-side output stage of a converter that samples two channels at once. A falling edge on the active-low start input raises `busy` for a fixed number of system clock cycles. When that time is up, `busy` drops and the two result words on `res_a` and `res_b` are latched. The analog conversion itself is not modelled; the result words stand in for it. A host reads the words through an active-low chip select and a serial clock. Every pin is sampled on the system clock `clk`.

Each channel has its own serial data line and its own output-enable flag. When the output enable is low, the line counts as high impedance and is driven to 0. The host can read both lanes in parallel. It can also keep chip select low for longer and read both words, one after the other, on a single lane. In a third use, chip select is tied low and the host takes the MSB at the moment `busy` falls. A new conversion can start while a read is in progress. The shift registers take the new words only when `busy` falls.

Top module: `dual_serial_out`

## Requirements
- R1: One cycle after the system clock samples a falling edge on `conv_start_n` while `busy` is low, `busy` goes high. It then stays high for exactly `CONV_CYCLES` cycles.
- R2: One cycle after chip select `cs_n` is sampled falling, `doe_a` and `doe_b` are 1. At that point `dout_a` carries bit `DATA_W-1` of the latched A word and `dout_b` carries the same bit of the latched B word.
- R3: Each serial-clock falling edge (`sclk` sampled 1 then 0) moves the next lower bit onto both lanes one cycle later, MSB first. This happens only while `cs_n` is low and `busy` is low, and a read covers `DATA_W` bits.
- R4: A serial-clock falling edge sampled in the same cycle as the chip-select falling edge does not shift. The MSB stays on the lane, and the next serial-clock falling edge presents bit `DATA_W-2`.
- R5: Keep chip select low after the first word and give 14 further falling edges. Each lane then outputs `14-DATA_W` zero bits and then the other channel's word, MSB first. Lane A continues with B and lane B continues with A.
- R6: One cycle after `cs_n` is sampled high, both output enables are 0 and both data lines are 0.
- R7: Serial-clock falling edges sampled while `busy` is high do not change either data line.
- R8: Suppose chip select is low when `busy` falls. In the cycle `busy` is first seen low, each lane carries the MSB of the new result word, and the output enables stay at 1.
- R9: After the chained word has been fully shifted out, further falling edges put 0 on the line for as long as chip select stays low.
- R10: While `cs_n` is held low across a conversion, the output enables never drop. A read in progress is replaced by the new words only when `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_n | input | 1 | Active-low conversion start; the falling edge starts a conversion |
| res_a | input | DATA_W | Result word of channel A, latched when busy falls |
| res_b | input | DATA_W | Result word of channel B, latched when busy falls |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; data moves on its falling edge |
| busy | output | 1 | High while a conversion is in progress |
| dout_a | output | 1 | Serial data of lane A (0 while not enabled) |
| doe_a | output | 1 | Output enable of lane A; 0 means high impedance |
| dout_b | output | 1 | Serial data of lane B (0 while not enabled) |
| doe_b | output | 1 | Output enable of lane B; 0 means high impedance |

## Verification
The dual-lane read is run with alternating-bit words, all-ones against all-zeros, and an irregular pair. The alternating and ones/zeros pairs expose a stuck or swapped lane and an off-by-one shift, and the irregular pair exposes bit-order mistakes. A long chained read checks the zero padding, the switch to the other channel's word and the trailing zeros. If the chain pointed at the wrong word or the pad had the wrong length, the sequence would shift visibly. Further sequences start a read before `busy` falls, send serial-clock edges during a conversion, and drop chip select together with a serial-clock fall. These separate edges that are really ignored from edges that are shifted late.

// File: rtl/sout_pkg.sv
package sout_pkg;

    // Number of serial-clock falls that carry the second (chained) word slot.
    localparam int unsigned CHAIN_SLOT = 14;

    // Edge events derived from the host and start pins in one system cycle.
    typedef struct packed {
        logic start_fall;
        logic cs_fall;
        logic cs_rise;
        logic sclk_fall;
    } pin_evt_t;

    // Lane register update selected in one cycle.
    typedef enum logic [1:0] {
        LN_HOLD   = 2'd0,
        LN_NEW    = 2'd1,
        LN_RELOAD = 2'd2,
        LN_SHIFT  = 2'd3
    } lane_op_t;

    // Width of a full chained frame for a given word width.
    function automatic int unsigned frame_width(input int unsigned word_w);
        return word_w + CHAIN_SLOT;
    endfunction

endpackage

// File: rtl/sout_edge.sv
module sout_edge
    import sout_pkg::*;
(
    input  logic     clk,
    input  logic     conv_start_n,
    input  logic     cs_n,
    input  logic     sclk,
    output pin_evt_t evt
);
    // Previous samples follow the pins even during reset so no false edge
    // is seen when reset is released.
    logic start_q;
    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        start_q <= conv_start_n;
        cs_q    <= cs_n;
        sclk_q  <= sclk;
    end

    always_comb begin
        evt.start_fall = start_q & ~conv_start_n;
        evt.cs_fall    = cs_q & ~cs_n;
        evt.cs_rise    = ~cs_q & cs_n;
        evt.sclk_fall  = sclk_q & ~sclk;
    end
endmodule

// File: rtl/sout_conv_timer.sv
module sout_conv_timer #(
    parameter int unsigned CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] remain;

    assign done = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                remain <= LOAD_VAL;
            end
        end else if (done) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/sout_lane.sv
module sout_lane
    import sout_pkg::*;
#(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  lane_op_t          op,
    input  logic [DATA_W-1:0] own_in,
    input  logic [DATA_W-1:0] other_in,
    output logic              bit_out
);
    localparam int unsigned FRAME_W = frame_width(DATA_W);

    logic [DATA_W-1:0]  own_q;
    logic [DATA_W-1:0]  other_q;
    logic [FRAME_W-1:0] shreg;

    // Own word on top, then the chain slot: zero pad followed by the other word.
    function automatic logic [FRAME_W-1:0] build_frame(
        input logic [DATA_W-1:0] first_w,
        input logic [DATA_W-1:0] second_w
    );
        return (FRAME_W'(first_w) << CHAIN_SLOT) | FRAME_W'(second_w);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q   <= '0;
            other_q <= '0;
            shreg   <= '0;
        end else begin
            case (op)
                LN_NEW: begin
                    own_q   <= own_in;
                    other_q <= other_in;
                    shreg   <= build_frame(own_in, other_in);
                end
                LN_RELOAD: shreg <= build_frame(own_q, other_q);
                LN_SHIFT:  shreg <= {shreg[FRAME_W-2:0], 1'b0};
                default:   shreg <= shreg;
            endcase
        end
    end

    assign bit_out = shreg[FRAME_W-1];
endmodule

// File: rtl/dual_serial_out.sv
module dual_serial_out
    import sout_pkg::*;
#(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned CONV_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start_n,
    input  logic [DATA_W-1:0] res_a,
    input  logic [DATA_W-1:0] res_b,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              busy,
    output logic              dout_a,
    output logic              doe_a,
    output logic              dout_b,
    output logic              doe_b
);
    localparam int unsigned N_LANES = 2;

    pin_evt_t evt;
    logic     conv_done;
    logic     oe_q;
    lane_op_t lane_op;

    logic [DATA_W-1:0] words   [N_LANES];
    logic              lane_bit[N_LANES];

    assign words[0] = res_a;
    assign words[1] = res_b;

    sout_edge u_edge (
        .clk          (clk),
        .conv_start_n (conv_start_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .evt          (evt)
    );

    sout_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (evt.start_fall),
        .busy  (busy),
        .done  (conv_done)
    );

    // New results win over a select-driven reload; a fall of the serial clock
    // in the same cycle as the select fall is dropped; conversion blocks shifts.
    always_comb begin
        if (conv_done)
            lane_op = LN_NEW;
        else if (evt.cs_fall)
            lane_op = LN_RELOAD;
        else if (evt.sclk_fall && !cs_n && !busy)
            lane_op = LN_SHIFT;
        else
            lane_op = LN_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst)
            oe_q <= 1'b0;
        else
            oe_q <= ~cs_n;
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        sout_lane #(
            .DATA_W (DATA_W)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .op       (lane_op),
            .own_in   (words[g]),
            .other_in (words[N_LANES-1-g]),
            .bit_out  (lane_bit[g])
        );
    end

    assign doe_a  = oe_q;
    assign doe_b  = oe_q;
    assign dout_a = oe_q & lane_bit[0];
    assign dout_b = oe_q & lane_bit[1];
endmodule

// File: rtl/sout_checker.sv
module sout_checker #(
    parameter int unsigned DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              conv_start_n,
    input logic [DATA_W-1:0] res_a,
    input logic [DATA_W-1:0] res_b,
    input logic              cs_n,
    input logic              busy,
    input logic              dout_a,
    input logic              doe_a,
    input logic              dout_b,
    input logic              doe_b
);
    a_r1_busy_rises: assert property (@(posedge clk) disable iff (rst)
        ($fell(conv_start_n) && !busy) |=> busy);

    a_r2_enable_on: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> (doe_a && doe_b));

    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!doe_a && !doe_b && !dout_a && !dout_b));

    a_r7_busy_freeze: assert property (@(posedge clk) disable iff (rst)
        (busy && !cs_n && $stable(cs_n)) |=>
            (($stable(dout_a) && $stable(dout_b)) || $fell(busy)));

    a_r8_msb_at_done: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && doe_a) |->
            (dout_a == $past(res_a[DATA_W-1]) && dout_b == $past(res_b[DATA_W-1])));
endmodule

bind dual_serial_out sout_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_start_n (conv_start_n),
    .res_a        (res_a),
    .res_b        (res_b),
    .cs_n         (cs_n),
    .busy         (busy),
    .dout_a       (dout_a),
    .doe_a        (doe_a),
    .dout_b       (dout_b),
    .doe_b        (doe_b)
);

// File: tb/dual_serial_out_test.sv
module dual_serial_out_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int CONV       = 20;
    localparam int SLOT       = 14;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_start_n = 1'b1;
    logic [W-1:0] res_a = '0;
    logic [W-1:0] res_b = '0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b1;
    logic         busy, dout_a, doe_a, dout_b, doe_b;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_serial_out #(.DATA_W(W), .CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst(rst), .conv_start_n(conv_start_n),
        .res_a(res_a), .res_b(res_b), .cs_n(cs_n), .sclk(sclk),
        .busy(busy), .dout_a(dout_a), .doe_a(doe_a),
        .dout_b(dout_b), .doe_b(doe_b)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic sclk_pulse();
        sclk = 1'b0;
        tick();
        sclk = 1'b1;
        tick();
    endtask

    // Expected bit i of a chained read: own word, zero pad, other word, zeros.
    function automatic logic exp_bit(input logic [W-1:0] own, input logic [W-1:0] oth, input int i);
        if (i < W)              return own[W-1-i];
        else if (i < SLOT)      return 1'b0;
        else if (i < SLOT + W)  return oth[SLOT+W-1-i];
        else                    return 1'b0;
    endfunction

    task automatic do_conv(input logic [W-1:0] a, input logic [W-1:0] b);
        int n;
        res_a = a;
        res_b = b;
        conv_start_n = 1'b0;
        tick();
        check("R1 busy raised", busy, 1);
        conv_start_n = 1'b1;
        n = 1;
        while (busy && n < 1000) begin
            tick();
            if (busy) n++;
        end
        check("R1 busy length", n, CONV);
    endtask

    task automatic read_dual(input logic [W-1:0] a, input logic [W-1:0] b);
        cs_n = 1'b0;
        tick();
        check("R2 doe_a on", doe_a, 1);
        check("R2 doe_b on", doe_b, 1);
        check("R2 msb lane A", dout_a, a[W-1]);
        check("R2 msb lane B", dout_b, b[W-1]);
        for (int i = 1; i < W; i++) begin
            sclk_pulse();
            check($sformatf("R3 lane A bit %0d", i), dout_a, a[W-1-i]);
            check($sformatf("R3 lane B bit %0d", i), dout_b, b[W-1-i]);
        end
        cs_n = 1'b1;
        tick();
        check("R6 doe_a off", doe_a, 0);
        check("R6 doe_b off", doe_b, 0);
        check("R6 dout_a low", dout_a, 0);
        check("R6 dout_b low", dout_b, 0);
    endtask

    task automatic test_coincident(input logic [W-1:0] a);
        cs_n = 1'b0;
        sclk = 1'b0;
        tick();
        check("R4 msb kept on coincident fall", dout_a, a[W-1]);
        sclk = 1'b1;
        tick();
        check("R4 msb still held", dout_a, a[W-1]);
        sclk_pulse();
        check("R4 first real fall gives bit 1", dout_a, a[W-2]);
        cs_n = 1'b1;
        tick();
    endtask

    task automatic test_chain(input logic [W-1:0] a, input logic [W-1:0] b);
        cs_n = 1'b0;
        tick();
        check("R5 chain start A", dout_a, a[W-1]);
        for (int i = 1; i < SLOT + W + 3; i++) begin
            sclk_pulse();
            if (i < SLOT + W) begin
                check($sformatf("R5 chain lane A bit %0d", i), dout_a, exp_bit(a, b, i));
                check($sformatf("R5 chain lane B bit %0d", i), dout_b, exp_bit(b, a, i));
            end else begin
                check($sformatf("R9 trailing zero A %0d", i), dout_a, 0);
                check($sformatf("R9 trailing zero B %0d", i), dout_b, 0);
            end
        end
        cs_n = 1'b1;
        tick();
    endtask

    task automatic test_busy_read(input logic [W-1:0] old_a, input logic [W-1:0] a, input logic [W-1:0] b);
        int guard;
        cs_n = 1'b0;
        tick();
        check("R2 old word msb", dout_a, old_a[W-1]);
        res_a = a;
        res_b = b;
        conv_start_n = 1'b0;
        tick();
        conv_start_n = 1'b1;
        check("R1 busy during read", busy, 1);
        for (int k = 0; k < 3; k++) begin
            sclk_pulse();
            check($sformatf("R7 no shift while busy %0d", k), dout_a, old_a[W-1]);
            check($sformatf("R7 lane B held %0d", k), dout_b, 1'b0);
        end
        guard = 0;
        while (busy && guard < 1000) begin
            tick();
            guard++;
        end
        check("R8 new msb lane A", dout_a, a[W-1]);
        check("R8 new msb lane B", dout_b, b[W-1]);
        check("R8 enable kept", doe_a, 1);
        sclk_pulse();
        check("R8 next bit after busy", dout_a, a[W-2]);
        cs_n = 1'b1;
        tick();
    endtask

    task automatic test_continuous(input logic [W-1:0] cur_a, input logic [W-1:0] a, input logic [W-1:0] b);
        int guard;
        cs_n = 1'b0;
        tick();
        for (int i = 1; i < 4; i++) sclk_pulse();
        check("R10 partial read", dout_a, cur_a[W-4]);
        res_a = a;
        res_b = b;
        conv_start_n = 1'b0;
        tick();
        conv_start_n = 1'b1;
        guard = 0;
        while (busy && guard < 1000) begin
            check("R10 enable held low-select", doe_a, 1);
            check("R10 old bit kept", dout_a, cur_a[W-4]);
            tick();
            guard++;
        end
        check("R10 new msb after busy", dout_a, a[W-1]);
        for (int i = 1; i < W; i++) begin
            sclk_pulse();
            check($sformatf("R10 new word bit %0d", i), dout_a, a[W-1-i]);
            check($sformatf("R10 enable bit %0d", i), doe_b, 1);
        end
        cs_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("reset busy", busy, 0);
        check("reset doe_a", doe_a, 0);
        check("reset dout_a", dout_a, 0);

        do_conv(12'hAAA, 12'h555);
        read_dual(12'hAAA, 12'h555);
        do_conv(12'hFFF, 12'h000);
        read_dual(12'hFFF, 12'h000);
        do_conv(12'hB3C, 12'h6D1);
        read_dual(12'hB3C, 12'h6D1);
        test_coincident(12'hB3C);
        test_chain(12'hB3C, 12'h6D1);
        read_dual(12'hB3C, 12'h6D1);
        do_conv(12'h7E5, 12'h000);
        test_busy_read(12'h7E5, 12'hC96, 12'h3A7);
        test_continuous(12'hC96, 12'h5F0, 12'hA1B);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule